// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits between a memory controller's write datapath and the ECC encoder of an ECC-protected DRAM. Its job is to corrupt stored bits on purpose, so that error reporting can be tested. Software first programs a target location, given as decoded DRAM coordinates: row, column, bank, bank group, rank, logical rank and channel. It also programs optional don't-care masks and, for each ECC lane, a pattern of bits to invert.

When a valid write arrives whose coordinates match the programmed target, each armed lane of the data word is XORed with its flip pattern before the word goes on to storage. A later read of that location then shows a correctable error (one flipped bit) or an uncorrectable error (two flipped bits). Writes that do not match pass through unchanged.

Each lane's flip pattern is held in two registers. The low register holds bit positions 0 to 30. The high register holds positions from 31 upward, with position p stored at bit p-31. A one-shot mode disarms the match after its first hit, so that exactly one write is poisoned. A persistent mode keeps corrupting every matching write.

Top module: `inj_ecc_wr_corrupt`

## Requirements
- R1: After a synchronous reset, every configuration register is zero, `out_valid` and `out_hit` are 0, and writes pass through unmodified with no hit.
- R2: A hit needs the enable bit set (bit 8 of the target-B register, register index 1). It also needs the unmasked coordinate bits to equal the target-A register (index 0), whose layout is row in bits 17:0, column in 27:18, bank in 29:28 and bank group in 31:30.
- R3: The target-B register compares rank in bits 1:0, logical rank in bits 4:2 and channel in bit 5. A mismatch in any one of these prevents a hit.
- R4: A 1 in mask register A (index 2) or mask register B (index 3, bits 5:0) removes the corresponding coordinate bit from the comparison. The value zero masks nothing.
- R5: For lane L, the low flip register (index 5+3L) supplies pattern bits 0 to 30 from its bits 30:0, and its bit 31 is discarded. The high flip register (index 6+3L) supplies pattern bits 31 and up, with position p at bit p-31. For 64-bit lanes, position 63 is never flipped.
- R6: Lane L is armed only when the low byte of its control register (index 4+3L) equals 0xFF. An unarmed lane passes its data unchanged even on a hit, while `out_hit` is still asserted.
- R7: On a hit, each armed lane's output is its input XOR its pattern, so one set bit gives a single-bit corruption and two set bits give a two-bit corruption. Without a hit the data is passed unchanged.
- R8: Outputs are registered with a latency of one cycle. `out_valid` follows `in_valid`, and an invalid cycle never reports a hit or corrupts data.
- R9: When the mode bit (bit 6 of target-B) is 0, the enable bit clears itself after the first hit. When the mode bit is 1, every matching write hits.
- R10: A configuration write in the same cycle as an access takes effect from the next cycle, so the access uses the previous values. A write to target-B takes priority over the one-shot self-clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | CFG_AW | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Write access present this cycle |
| in_row | input | 18 | Decoded row of the access |
| in_col | input | 10 | Decoded column |
| in_bank | input | 2 | Decoded bank |
| in_grp | input | 2 | Decoded bank group |
| in_rank | input | 2 | Decoded rank |
| in_lrank | input | 3 | Decoded logical rank |
| in_chan | input | 1 | Decoded channel |
| in_data | input | NUM_LANES*LANE_W | Write data, lane 0 in the low bits |
| out_valid | output | 1 | Registered copy of in_valid |
| out_hit | output | 1 | The registered access matched the target |
| out_data | output | NUM_LANES*LANE_W | Write data after optional corruption |

## Verification
The bench builds the block with its default parameters: two lanes of 64 bits and a 4-bit register index. With these values, the split between the low and high flip registers at position 31 is reachable, and so are the highest reachable position 62 and the unreachable position 63. The test steers single coordinate bits across every field of both target words, with and without masks. It covers arming codes that differ from 0xFF in only one bit. It also covers configuration writes that coincide with matching accesses, in both one-shot and persistent modes.

// File: rtl/inj_pkg.sv
`timescale 1ns/1ps
package inj_pkg;
  localparam int REG_W   = 32;
  localparam int ROW_W   = 18;
  localparam int COL_W   = 10;
  localparam int BANK_W  = 2;
  localparam int GRP_W   = 2;
  localparam int RANK_W  = 2;
  localparam int LRANK_W = 3;
  localparam int CH_W    = 1;

  // target word A: row | col | bank | group, row at the bottom
  localparam int COL_LSB  = ROW_W;
  localparam int BANK_LSB = COL_LSB + COL_W;
  localparam int GRP_LSB  = BANK_LSB + BANK_W;
  localparam int CA_W     = GRP_LSB + GRP_W;

  // target word B: rank | logical rank | channel, then mode and enable
  localparam int LRANK_LSB = RANK_W;
  localparam int CH_LSB    = LRANK_LSB + LRANK_W;
  localparam int CB_W      = CH_LSB + CH_W;
  localparam int MODE_BIT  = 6;
  localparam int EN_BIT    = 8;

  // flip pattern split: positions below SPLIT live in the low word
  localparam int SPLIT = 31;
  localparam logic [7:0] ARM_CODE = 8'hFF;

  // register indices
  localparam int REG_MATCH_A   = 0;
  localparam int REG_MATCH_B   = 1;
  localparam int REG_MASK_A    = 2;
  localparam int REG_MASK_B    = 3;
  localparam int REG_LANE0     = 4;
  localparam int REGS_PER_LANE = 3;

  typedef logic [CA_W-1:0] coord_a_t;
  typedef logic [CB_W-1:0] coord_b_t;

  typedef struct packed {
    logic     en;
    logic     mode;
    coord_b_t coords;
  } match_b_t;
endpackage

// File: rtl/inj_cfg_regs.sv
`timescale 1ns/1ps
module inj_cfg_regs
  import inj_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int CFG_AW    = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_we,
  input  logic [CFG_AW-1:0]                  cfg_addr,
  input  logic [REG_W-1:0]                   cfg_wdata,
  input  logic                               oneshot_hit,
  output coord_a_t                           match_a,
  output coord_a_t                           mask_a,
  output match_b_t                           match_b,
  output coord_b_t                           mask_b,
  output logic [NUM_LANES-1:0][7:0]          lane_ctrl,
  output logic [NUM_LANES-1:0][SPLIT-1:0]    flip_lo,
  output logic [NUM_LANES-1:0][REG_W-1:0]    flip_hi
);
  logic wr_a, wr_b, wr_ka, wr_kb;

  assign wr_a  = cfg_we && (cfg_addr == CFG_AW'(REG_MATCH_A));
  assign wr_b  = cfg_we && (cfg_addr == CFG_AW'(REG_MATCH_B));
  assign wr_ka = cfg_we && (cfg_addr == CFG_AW'(REG_MASK_A));
  assign wr_kb = cfg_we && (cfg_addr == CFG_AW'(REG_MASK_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_a <= '0;
      mask_a  <= '0;
      match_b <= '0;
      mask_b  <= '0;
    end else begin
      if (wr_a)  match_a <= cfg_wdata[CA_W-1:0];
      if (wr_ka) mask_a  <= cfg_wdata[CA_W-1:0];
      if (wr_kb) mask_b  <= cfg_wdata[CB_W-1:0];
      if (wr_b) begin
        match_b.en     <= cfg_wdata[EN_BIT];
        match_b.mode   <= cfg_wdata[MODE_BIT];
        match_b.coords <= cfg_wdata[CB_W-1:0];
      end else if (oneshot_hit && !match_b.mode) begin
        match_b.en <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_regs
    localparam int CTRL_IDX = REG_LANE0 + REGS_PER_LANE * l;
    logic wr_ctrl, wr_lo, wr_hi;
    assign wr_ctrl = cfg_we && (cfg_addr == CFG_AW'(CTRL_IDX));
    assign wr_lo   = cfg_we && (cfg_addr == CFG_AW'(CTRL_IDX + 1));
    assign wr_hi   = cfg_we && (cfg_addr == CFG_AW'(CTRL_IDX + 2));

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_ctrl[l] <= '0;
        flip_lo[l]   <= '0;
        flip_hi[l]   <= '0;
      end else begin
        if (wr_ctrl) lane_ctrl[l] <= cfg_wdata[7:0];
        if (wr_lo)   flip_lo[l]   <= cfg_wdata[SPLIT-1:0];
        if (wr_hi)   flip_hi[l]   <= cfg_wdata;
      end
    end
  end

  // one-shot mode drops the enable after a hit (R9)
  p_oneshot_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (oneshot_hit && !match_b.mode && !wr_b) |=> !match_b.en);

  // persistent mode keeps the enable across hits (R9)
  p_persist_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (oneshot_hit && match_b.mode && !wr_b) |=> match_b.en);

  // a target-B write beats the self-clear (R10)
  p_cfg_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_b |=> (match_b.en == $past(cfg_wdata[EN_BIT])));
endmodule

// File: rtl/inj_match.sv
`timescale 1ns/1ps
module inj_match
  import inj_pkg::*;
(
  input  coord_a_t coord_a,
  input  coord_b_t coord_b,
  input  coord_a_t match_a,
  input  coord_a_t mask_a,
  input  match_b_t match_b,
  input  coord_b_t mask_b,
  output logic     hit
);
  coord_a_t diff_a;
  coord_b_t diff_b;

  always_comb begin
    diff_a = (coord_a ^ match_a) & ~mask_a;
    diff_b = (coord_b ^ match_b.coords) & ~mask_b;
    hit    = match_b.en && (diff_a == '0) && (diff_b == '0);
  end
endmodule

// File: rtl/inj_lane_flip.sv
`timescale 1ns/1ps
module inj_lane_flip
  import inj_pkg::*;
#(
  parameter int LANE_W = 64
) (
  input  logic [LANE_W-1:0] lane_in,
  input  logic [7:0]        ctrl,
  input  logic [SPLIT-1:0]  flip_lo,
  input  logic [REG_W-1:0]  flip_hi,
  output logic [LANE_W-1:0] lane_out
);
  localparam int PAT_W = SPLIT + REG_W;

  logic [PAT_W-1:0]  full_pat;
  logic [LANE_W-1:0] pattern;
  logic              armed;

  assign full_pat = {flip_hi, flip_lo};
  assign armed    = (ctrl == ARM_CODE);

  if (LANE_W > PAT_W) begin : g_pad
    assign pattern = {{(LANE_W - PAT_W){1'b0}}, full_pat};
  end else begin : g_trim
    assign pattern = full_pat[LANE_W-1:0];
  end

  assign lane_out = armed ? (lane_in ^ pattern) : lane_in;
endmodule

// File: rtl/inj_ecc_wr_corrupt.sv
`timescale 1ns/1ps
module inj_ecc_wr_corrupt
  import inj_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int LANE_W    = 64,
  parameter int CFG_AW    = $clog2(REG_LANE0 + REGS_PER_LANE * NUM_LANES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [REG_W-1:0]              cfg_wdata,
  input  logic                          in_valid,
  input  logic [ROW_W-1:0]              in_row,
  input  logic [COL_W-1:0]              in_col,
  input  logic [BANK_W-1:0]             in_bank,
  input  logic [GRP_W-1:0]              in_grp,
  input  logic [RANK_W-1:0]             in_rank,
  input  logic [LRANK_W-1:0]            in_lrank,
  input  logic [CH_W-1:0]               in_chan,
  input  logic [NUM_LANES*LANE_W-1:0]   in_data,
  output logic                          out_valid,
  output logic                          out_hit,
  output logic [NUM_LANES*LANE_W-1:0]   out_data
);
  localparam int DATA_W = NUM_LANES * LANE_W;

  coord_a_t match_a, mask_a;
  coord_b_t mask_b;
  match_b_t match_b;
  logic [NUM_LANES-1:0][7:0]       lane_ctrl;
  logic [NUM_LANES-1:0][SPLIT-1:0] flip_lo;
  logic [NUM_LANES-1:0][REG_W-1:0] flip_hi;

  coord_a_t          coord_a;
  coord_b_t          coord_b;
  logic              hit_raw;
  logic              hit;
  logic [DATA_W-1:0] flipped;

  assign coord_a = {in_grp, in_bank, in_col, in_row};
  assign coord_b = {in_chan, in_lrank, in_rank};
  assign hit     = in_valid && hit_raw;

  inj_cfg_regs #(.NUM_LANES(NUM_LANES), .CFG_AW(CFG_AW)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .oneshot_hit (hit),
    .match_a     (match_a),
    .mask_a      (mask_a),
    .match_b     (match_b),
    .mask_b      (mask_b),
    .lane_ctrl   (lane_ctrl),
    .flip_lo     (flip_lo),
    .flip_hi     (flip_hi)
  );

  inj_match u_match (
    .coord_a (coord_a),
    .coord_b (coord_b),
    .match_a (match_a),
    .mask_a  (mask_a),
    .match_b (match_b),
    .mask_b  (mask_b),
    .hit     (hit_raw)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    inj_lane_flip #(.LANE_W(LANE_W)) u_flip (
      .lane_in  (in_data[l*LANE_W +: LANE_W]),
      .ctrl     (lane_ctrl[l]),
      .flip_lo  (flip_lo[l]),
      .flip_hi  (flip_hi[l]),
      .lane_out (flipped[l*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= hit;
      out_data  <= hit ? flipped : in_data;
    end
  end

  // disabled target never reports a hit (R2)
  p_disabled_no_hit_r2: assert property (@(posedge clk) disable iff (rst)
    !match_b.en |=> !out_hit);

  // fully masked coordinates always hit while enabled (R4)
  p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && match_b.en && (&mask_a) && (&mask_b)) |=> out_hit);

  // non-hitting traffic is untouched one cycle later (R7)
  p_passthru_r7: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (out_data == $past(in_data)));

  // one-cycle registered handshake (R8)
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_hit));
endmodule

// File: tb/inj_ecc_wr_corrupt_test.sv
`timescale 1ns/1ps
module inj_ecc_wr_corrupt_test;
  localparam int DW = 128;

  localparam logic [17:0] R0  = 18'h2A5C3;
  localparam logic [9:0]  C0  = 10'h1B7;
  localparam logic [1:0]  BK0 = 2'd2;
  localparam logic [1:0]  G0  = 2'd1;
  localparam logic [1:0]  RK0 = 2'd3;
  localparam logic [2:0]  LR0 = 3'd5;
  localparam logic        CH0 = 1'b1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          in_valid = 1'b0;
  logic [17:0]   in_row = '0;
  logic [9:0]    in_col = '0;
  logic [1:0]    in_bank = '0, in_grp = '0, in_rank = '0;
  logic [2:0]    in_lrank = '0;
  logic          in_chan = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_hit;
  logic [DW-1:0] out_data;

  always #2 clk = ~clk;

  inj_ecc_wr_corrupt uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_row(in_row), .in_col(in_col), .in_bank(in_bank),
    .in_grp(in_grp), .in_rank(in_rank), .in_lrank(in_lrank), .in_chan(in_chan),
    .in_data(in_data), .out_valid(out_valid), .out_hit(out_hit), .out_data(out_data)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg [10];
  logic          exp_valid = 1'b0, exp_hit = 1'b0;
  logic [DW-1:0] exp_data = '0;
  int vectors = 0, fails = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";

  function automatic logic [63:0] lane_pattern(input logic [31:0] ctl, lo, hi);
    logic [63:0] r = '0;
    if (ctl[7:0] != 8'hFF) return r;
    for (int p = 0; p < 64; p++) begin
      if (p < 31)      r[p] = lo[p];
      else if (p < 63) r[p] = hi[p-31];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    logic [31:0] wa, wb;
    logic        h;
    if (rst) begin
      for (int i = 0; i < 10; i++) m_reg[i] = '0;
      exp_valid = 0; exp_hit = 0; exp_data = '0;
    end else begin
      wa = 32'(in_row) | (32'(in_col) << 18) | (32'(in_bank) << 28) | (32'(in_grp) << 30);
      wb = 32'(in_rank) | (32'(in_lrank) << 2) | (32'(in_chan) << 5);
      h = in_valid && m_reg[1][8] && (((wa ^ m_reg[0]) & ~m_reg[2]) == 0)
          && ((((wb ^ m_reg[1]) & ~m_reg[3]) & 32'h3F) == 0);
      exp_valid = in_valid;
      exp_hit   = h;
      exp_data  = in_data;
      if (h) begin
        for (int l = 0; l < 2; l++)
          exp_data[l*64 +: 64] = in_data[l*64 +: 64]
            ^ lane_pattern(m_reg[4+3*l], m_reg[5+3*l], m_reg[6+3*l]);
      end
      if (cfg_we) m_reg[cfg_addr] = cfg_wdata;
      else if (h && !m_reg[1][6]) m_reg[1][8] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      vectors++;
      if (out_valid !== exp_valid || out_hit !== exp_hit || out_data !== exp_data) begin
        fails++;
        $display("FAIL %s: valid/hit/data=%0b/%0b/%h expected %0b/%0b/%h",
                 cur_req, out_valid, out_hit, out_data, exp_valid, exp_hit, exp_data);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [31:0] tgt_a();
    return 32'(R0) | (32'(C0) << 18) | (32'(BK0) << 28) | (32'(G0) << 30);
  endfunction

  function automatic logic [31:0] tgt_b();
    return 32'(RK0) | (32'(LR0) << 2) | (32'(CH0) << 5);
  endfunction

  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] wd,
                     input logic v, input logic [17:0] r, input logic [9:0] c,
                     input logic [1:0] bk, input logic [1:0] gp, input logic [1:0] rk,
                     input logic [2:0] lr, input logic ch, input logic [127:0] d);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    in_valid = v; in_row = r; in_col = c; in_bank = bk; in_grp = gp;
    in_rank = rk; in_lrank = lr; in_chan = ch; in_data = d;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] wd);
    cyc(1'b1, a, wd, 1'b0, R0, C0, BK0, G0, RK0, LR0, CH0, rnd128());
  endtask

  task automatic acc(input logic [17:0] r, input logic [9:0] c, input logic [1:0] bk,
                     input logic [1:0] gp, input logic [1:0] rk, input logic [2:0] lr,
                     input logic ch);
    cyc(1'b0, 4'd0, 32'd0, 1'b1, r, c, bk, gp, rk, lr, ch, rnd128());
  endtask

  task automatic acc_base();
    acc(R0, C0, BK0, G0, RK0, LR0, CH0);
  endtask

  task automatic idle();
    cyc(1'b0, 4'd0, 32'd0, 1'b0, R0, C0, BK0, G0, RK0, LR0, CH0, rnd128());
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL R8: watchdog expired, run incomplete (expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    chk_on = 1;
    cur_req = "R1";                       // reset state and idle registers
    @(negedge clk); @(negedge clk);
    rst = 0;
    acc_base();
    acc(R0 ^ 18'h1, C0, BK0, G0, RK0, LR0, CH0);

    cur_req = "R2";
    wr(0, tgt_a());
    wr(1, tgt_b() | (32'd1 << 6));        // enable still off
    wr(4, 32'hFF); wr(5, 32'd1 << 3); wr(6, 0);
    wr(7, 32'hFF); wr(8, 32'd1 << 3); wr(9, 0);
    acc_base();                           // no hit while disabled
    wr(1, tgt_b() | (32'd1 << 6) | (32'd1 << 8));
    acc_base();
    acc(R0 ^ (18'd1 << 17), C0, BK0, G0, RK0, LR0, CH0);
    acc(R0, C0 ^ 10'd1, BK0, G0, RK0, LR0, CH0);
    acc(R0, C0 ^ (10'd1 << 9), BK0, G0, RK0, LR0, CH0);
    acc(R0, C0, BK0 ^ 2'd2, G0, RK0, LR0, CH0);
    acc(R0, C0, BK0, G0 ^ 2'd1, RK0, LR0, CH0);
    acc(R0, C0, BK0, G0 ^ 2'd2, RK0, LR0, CH0);

    cur_req = "R3";
    acc(R0, C0, BK0, G0, RK0 ^ 2'd1, LR0, CH0);
    acc(R0, C0, BK0, G0, RK0, LR0 ^ 3'd4, CH0);
    acc(R0, C0, BK0, G0, RK0, LR0, ~CH0);
    acc_base();

    cur_req = "R4";
    wr(2, 32'd1);
    acc(R0 ^ 18'd1, C0, BK0, G0, RK0, LR0, CH0);
    acc(R0 ^ 18'd2, C0, BK0, G0, RK0, LR0, CH0);
    wr(3, 32'd1 << 5);
    acc(R0, C0, BK0, G0, RK0, LR0, ~CH0);
    acc(R0, C0, BK0, G0, RK0 ^ 2'd1, LR0, CH0);
    wr(2, 0); wr(3, 0);
    acc(R0 ^ 18'd1, C0, BK0, G0, RK0, LR0, CH0);

    cur_req = "R5";
    wr(5, 32'd1 << 30); wr(6, 32'd1 | (32'd1 << 31));
    wr(8, 32'h8000_0000); wr(9, 32'd1);
    acc_base(); acc_base();
    wr(6, 32'hFFFF_FFFF);
    acc_base();

    cur_req = "R6";
    wr(7, 32'hFE);
    acc_base();
    wr(7, 32'h7F);
    acc_base();
    wr(7, 32'h1FF);
    acc_base();

    cur_req = "R7";
    wr(5, (32'd1 << 5) | (32'd1 << 17)); wr(6, 32'd1 << 9);
    wr(8, 32'd3); wr(9, 0);
    cyc(1'b0, 4'd0, 32'd0, 1'b1, R0, C0, BK0, G0, RK0, LR0, CH0, '0);
    cyc(1'b0, 4'd0, 32'd0, 1'b1, R0, C0, BK0, G0, RK0, LR0, CH0, '1);
    acc_base();

    cur_req = "R8";
    idle();
    idle();
    acc_base();

    cur_req = "R9";
    wr(1, tgt_b() | (32'd1 << 8));        // one-shot
    acc_base(); acc_base(); acc_base();
    wr(1, tgt_b() | (32'd1 << 6) | (32'd1 << 8));
    acc_base(); acc_base();

    cur_req = "R10";
    cyc(1'b1, 4'd0, tgt_a() ^ 32'd1, 1'b1, R0, C0, BK0, G0, RK0, LR0, CH0, rnd128());
    acc_base();
    wr(0, tgt_a());
    wr(1, tgt_b() | (32'd1 << 8));
    cyc(1'b1, 4'd1, tgt_b() | (32'd1 << 8), 1'b1, R0, C0, BK0, G0, RK0, LR0, CH0, rnd128());
    acc_base(); acc_base();
    idle(); idle();

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule